// File: doc/BRIEF.md
# Ethernet Port Status LED Controller

This block drives fifteen indicator LEDs for a five-port Ethernet switch, three per port. Software programs four 32-bit control words over a simple register bus. Each LED has a two-bit mode field with four settings: dark, lit, a fixed 4 Hz blink, or "rule" mode. In rule mode the LED follows the port's live PHY status: link, speed, duplex, and transmit, receive and collision activity.

Six 16-bit rule words describe what a rule-mode LED shows. LED slot n of ports 0 to 3 shares one rule word. LED slot n of port 4 has its own. A rule enables link speeds and duplex settings for a steady light. It can also make traffic pulses stretch into a visible blink at 2, 4 or 8 Hz, or at a rate picked from the link speed. An internal divider turns the system clock into a phase unit of about 62.5 ms, from which all blink rates are derived.

Top module: `port_led_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four control words read zero and every LED output is low.
- R2: Mode value 0 drives the LED low and mode value 2 drives it high. An LED output reflects the stored control words and port inputs one clock edge after they are sampled, so a register write shows on the LED two edges after the write is presented.
- R3: Mode value 1 drives a square wave of period 4 phase units: 2 units high, then 2 units low.
- R4: The mode field of LED n (n = 0..2) sits at bits [15:14] of control word n for port 0, and at bits [31:30] of control word n for port 4. For port p = 1..3 it sits in control word 3 at bit 8 + 2n + 6(p-1). The LED output index is 3p + n.
- R5: For a rule-mode LED n, the rule word is bits [15:0] of control word n for ports 0 to 3, and bits [31:16] of control word n for port 4.
- R6: The steady level of a rule-mode LED is high when either of two conditions holds. The first is power-on light (rule bit 11). The second is a link that is up at an enabled speed (speed code 0 = 10M with bit 8, 1 = 100M with bit 9, 2 = 1000M with bit 10; code 3 never matches) and whose duplex is accepted. Duplex is accepted when rule bit 13 is set and the port is full duplex, when rule bit 12 is set and the port is half duplex, or when both bits are clear.
- R7: A TX pulse with rule bit 4, an RX pulse with bit 5, or a collision pulse with bit 7 opens an activity window that lasts 8 phase units after the last such pulse. Inside the window the LED blinks at the rate set by rule bits [1:0]: 0 = period 8 units, 1 = period 4 units, 2 = period 2 units. The blink replaces the steady level.
- R8: Rule rate code 3 selects the blink rate from the port speed: period 2 units at 1000M, 4 units at 100M, and 8 units at 10M or unknown speed.
- R9: With rule bit 2 set and the steady condition true, the LED stays high even inside an activity window.
- R10: Control word i is at byte address BASE_ADDR + 4i. A write takes effect on the next clock edge. The read data is the stored word for the current address with no wait cycle. Any other address, including a misaligned one, reads zero and ignores writes.
- R11: One phase unit is DIV clock cycles. The 2 Hz, 4 Hz and 8 Hz waves change level every 4, 2 and 1 phase units respectively, all low at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| port_link | input | 5 | Link up, one bit per port |
| port_speed | input | 10 | Speed code per port, bits [2p+1:2p] (0 = 10M, 1 = 100M, 2 = 1000M, 3 = unknown) |
| port_fdx | input | 5 | Full duplex (1) or half duplex (0), per port |
| port_tx | input | 5 | TX activity pulse per port |
| port_rx | input | 5 | RX activity pulse per port |
| port_col | input | 5 | Collision pulse per port |
| led_out | output | 15 | LED drive, index 3p + n |

## Verification
The bench builds the block with DIV = 4, so one phase unit is four clocks. At that setting the slowest blink period is 32 cycles and an activity window is at most 32 cycles. Many full periods of every rate, window expiries and rate changes therefore fit in a few thousand cycles. The default address width and base are used, so the unmapped, misaligned and neighbouring addresses are exercised with the real decode.

// File: rtl/pled_pkg.sv
// Package: shared constants and types for the port LED controller.
// Assumes a fixed five-port, three-LED-per-port layout; the mode-field
// and rule-word placement depends on these counts and is not scalable.
package pled_pkg;

    localparam int PORTS     = 5;
    localparam int LEDS_PP   = 3;
    localparam int LED_NUM   = PORTS * LEDS_PP;
    localparam int NREG      = 4;
    localparam int REG_W     = 32;
    localparam int RULE_W    = 16;
    localparam int PHASE_W   = 3;
    localparam int HOLD_W    = PHASE_W + 1;
    localparam int HOLD_UNITS = 2 ** PHASE_W;

    // Rule word bit positions
    localparam int RB_OVERRIDE = 2;
    localparam int RB_TX       = 4;
    localparam int RB_RX       = 5;
    localparam int RB_COL      = 7;
    localparam int RB_SPD10    = 8;
    localparam int RB_SPD100   = 9;
    localparam int RB_SPD1000  = 10;
    localparam int RB_POWER    = 11;
    localparam int RB_HALF     = 12;
    localparam int RB_FULL     = 13;

    typedef enum logic [1:0] {
        LM_DARK  = 2'd0,
        LM_BLINK = 2'd1,
        LM_LIT   = 2'd2,
        LM_RULE  = 2'd3
    } led_mode_e;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'd0,
        RATE_MID  = 2'd1,
        RATE_FAST = 2'd2,
        RATE_AUTO = 2'd3
    } blink_rate_e;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_NONE = 2'd3
    } link_speed_e;

endpackage

// File: rtl/pled_regs.sv
// Module: register file of four 32-bit control words.
// Assumes BASE_ADDR is 16-byte aligned. Only word-aligned addresses
// inside the four-word window hit. Read data is combinational.
module pled_regs
    import pled_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output logic [NREG*REG_W-1:0]  words
);

    logic [REG_W-1:0] mem [NREG];
    logic             hit;
    logic [1:0]       idx;

    // Address decode: aligned hit inside the control window
    always_comb begin
        hit = (addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
        idx = addr[3:2];
    end

    // Storage update on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr && hit) begin
            mem[idx] <= wdata;
        end
    end

    // Read mux: stored word for a hit, zero otherwise
    always_comb begin
        rdata = hit ? mem[idx] : '0;
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_word
            assign words[g*REG_W +: REG_W] = mem[g];

            p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && hit && (idx == g)) |=> (mem[g] == $past(wdata)));
        end
    endgenerate

    p_unmapped_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> $stable(words));

endmodule

// File: rtl/pled_timebase.sv
// Module: blink timebase. Divides the clock by DIV into one phase unit
// and counts units in a small phase counter whose bits are the
// 8 Hz, 4 Hz and 2 Hz square waves. Assumes DIV >= 1.
module pled_timebase
    import pled_pkg::*;
#(
    parameter int DIV = 6250000
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               tick,
    output logic [PHASE_W-1:0] phase
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Unit boundary flag
    always_comb tick = (cnt == CNT_LAST);

    // Clock divider
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Phase unit counter
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= phase + 1'b1;
    end

    p_phase_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
    p_phase_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/pled_lane.sv
// Module: decision logic for one LED. Combines its mode field, its
// rule word and its port's status into a registered LED level. Holds an
// activity window counter in phase units. Assumes the phase waves and
// tick come from one shared timebase.
module pled_lane
    import pled_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [RULE_W-1:0]  rule,
    input  logic               link,
    input  logic [1:0]         speed,
    input  logic               fdx,
    input  logic               tx,
    input  logic               rx,
    input  logic               col,
    input  logic               tick,
    input  logic [PHASE_W-1:0] phase,
    output logic               led
);

    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_UNITS);

    logic [HOLD_W-1:0] hold;
    logic              evt, spd_ok, dup_ok, steady, wave, active, nxt;
    logic [1:0]        rate;

    // Activity event: any enabled traffic pulse
    always_comb evt = (tx && rule[RB_TX]) || (rx && rule[RB_RX]) || (col && rule[RB_COL]);

    // Steady condition from link, speed, duplex and power-on light
    always_comb begin
        unique case (link_speed_e'(speed))
            SPD_10:   spd_ok = link && rule[RB_SPD10];
            SPD_100:  spd_ok = link && rule[RB_SPD100];
            SPD_1000: spd_ok = link && rule[RB_SPD1000];
            default:  spd_ok = 1'b0;
        endcase
        dup_ok = (!rule[RB_FULL] && !rule[RB_HALF]) ||
                 (fdx ? rule[RB_FULL] : rule[RB_HALF]);
        steady = (spd_ok && dup_ok) || rule[RB_POWER];
    end

    // Blink rate selection, automatic rate follows link speed
    always_comb begin
        rate = rule[1:0];
        if (blink_rate_e'(rate) == RATE_AUTO) begin
            unique case (link_speed_e'(speed))
                SPD_1000: rate = RATE_FAST;
                SPD_100:  rate = RATE_MID;
                default:  rate = RATE_SLOW;
            endcase
        end
        unique case (blink_rate_e'(rate))
            RATE_FAST: wave = phase[0];
            RATE_MID:  wave = phase[1];
            default:   wave = phase[2];
        endcase
    end

    // Activity window counter, reloaded by every event
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold <= '0;
        else if (evt)                   hold <= HOLD_LOAD;
        else if (tick && hold != '0)    hold <= hold - 1'b1;
    end

    // Next LED level by mode
    always_comb begin
        active = (hold != '0);
        unique case (led_mode_e'(mode))
            LM_DARK:  nxt = 1'b0;
            LM_BLINK: nxt = phase[1];
            LM_LIT:   nxt = 1'b1;
            default:  nxt = (active && !(rule[RB_OVERRIDE] && steady)) ? wave : steady;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) led <= 1'b0;
        else        led <= nxt;
    end

    p_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_DARK) |=> !led);
    p_lit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_LIT) |=> led);
    p_window_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (hold == HOLD_LOAD));
    p_override_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_RULE && rule[RB_OVERRIDE] && steady) |=> led);

endmodule

// File: rtl/port_led_ctrl.sv
// Module: top of the port LED controller. Slices each LED's mode field
// and rule word out of the four control words and instantiates one
// decision lane per LED. Assumes status inputs are synchronous to clk.
module port_led_ctrl
    import pled_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50,
    parameter int                DIV       = 6250000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [PORTS-1:0]     port_link,
    input  logic [2*PORTS-1:0]   port_speed,
    input  logic [PORTS-1:0]     port_fdx,
    input  logic [PORTS-1:0]     port_tx,
    input  logic [PORTS-1:0]     port_rx,
    input  logic [PORTS-1:0]     port_col,
    output logic [LED_NUM-1:0]   led_out
);

    logic [NREG*REG_W-1:0] words;
    logic                  tick;
    logic [PHASE_W-1:0]    phase;

    pled_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .words (words)
    );

    pled_timebase #(.DIV(DIV)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .phase (phase)
    );

    genvar gp, gn;
    generate
        for (gp = 0; gp < PORTS; gp++) begin : g_port
            for (gn = 0; gn < LEDS_PP; gn++) begin : g_led
                // Mode field location: ports 1..3 packed into the last word
                localparam int MREG = (gp == 0 || gp == PORTS - 1) ? gn : NREG - 1;
                localparam int MLSB = (gp == 0) ? 14 :
                                      (gp == PORTS - 1) ? 30 :
                                      8 + 2 * gn + 6 * (gp - 1);
                // Rule word: lower half shared by ports 0..3, upper half for port 4
                localparam int RLSB = gn * REG_W + ((gp == PORTS - 1) ? RULE_W : 0);

                pled_lane u_lane (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .mode  (words[MREG*REG_W + MLSB +: 2]),
                    .rule  (words[RLSB +: RULE_W]),
                    .link  (port_link[gp]),
                    .speed (port_speed[2*gp +: 2]),
                    .fdx   (port_fdx[gp]),
                    .tx    (port_tx[gp]),
                    .rx    (port_rx[gp]),
                    .col   (port_col[gp]),
                    .tick  (tick),
                    .phase (phase),
                    .led   (led_out[gp*LEDS_PP + gn])
                );
            end
        end
    endgenerate

    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |=> (led_out == '0 && words == '0));

endmodule

// File: tb/port_led_ctrl_bench.sv
module port_led_ctrl_bench;

    localparam int DIV = 4;
    localparam int NL  = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  port_link = '0;
    logic [9:0]  port_speed = '0;
    logic [4:0]  port_fdx = '0;
    logic [4:0]  port_tx = '0;
    logic [4:0]  port_rx = '0;
    logic [4:0]  port_col = '0;
    logic [14:0] led_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    port_led_ctrl #(.ADDR_W(8), .BASE_ADDR(8'h50), .DIV(DIV)) u_port_led_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_link(port_link),
        .port_speed(port_speed), .port_fdx(port_fdx), .port_tx(port_tx),
        .port_rx(port_rx), .port_col(port_col), .led_out(led_out)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_regs [4];
    int          m_div, m_ph;
    int          m_hold [NL];
    logic        m_led [NL];
    string       m_tag [NL];
    int          tk;

    function automatic int m_mode(int p, int n);
        if (p == 0) return int'((m_regs[n] >> 14) & 3);
        if (p == 4) return int'((m_regs[n] >> 30) & 3);
        return int'((m_regs[3] >> (8 + 2*n + 6*(p-1))) & 3);
    endfunction

    function automatic logic [15:0] m_rule(int p, int n);
        if (p == 4) return m_regs[n][31:16];
        return m_regs[n][15:0];
    endfunction

    function automatic logic m_level(int p, int n);
        int md, spd, r;
        logic [15:0] rl;
        logic st, dup, wv;
        md = m_mode(p, n);
        rl = m_rule(p, n);
        spd = int'(port_speed[2*p +: 2]);
        if (md == 0) return 1'b0;
        if (md == 2) return 1'b1;
        if (md == 1) return logic'((m_ph >> 1) & 1);
        if (rl[13] == 1'b0 && rl[12] == 1'b0) dup = 1'b1;
        else dup = port_fdx[p] ? rl[13] : rl[12];
        st = (port_link[p] && spd < 3 && rl[8 + spd] && dup) || rl[11];
        r = int'(rl[1:0]);
        if (r == 3) r = (spd == 2) ? 2 : (spd == 1) ? 1 : 0;
        wv = logic'((m_ph >> (2 - r)) & 1);
        if (m_hold[3*p+n] > 0 && !(rl[2] && st)) return wv;
        return st;
    endfunction

    // Model advance on each clock edge, using pre-edge state and inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_regs[i] = '0;
            for (int i = 0; i < NL; i++) begin m_hold[i] = 0; m_led[i] = 1'b0; m_tag[i] = "R1"; end
            m_div = 0; m_ph = 0;
        end else begin
            tk = (m_div == DIV - 1) ? 1 : 0;
            for (int i = 0; i < NL; i++) begin
                int md;
                md = m_mode(i/3, i%3);
                m_led[i] = m_level(i/3, i%3);
                m_tag[i] = (md == 1) ? "R3" : (md == 3) ? "R6" : "R2";
            end
            for (int i = 0; i < NL; i++) begin
                logic [15:0] rl;
                int p;
                p = i/3;
                rl = m_rule(p, i%3);
                if ((port_tx[p] && rl[4]) || (port_rx[p] && rl[5]) || (port_col[p] && rl[7]))
                    m_hold[i] = 8;
                else if (tk == 1 && m_hold[i] > 0)
                    m_hold[i] = m_hold[i] - 1;
            end
            if (tk == 1) begin m_ph = (m_ph + 1) % 8; m_div = 0; end
            else m_div = m_div + 1;
            if (bus_wr && bus_addr[7:4] == 4'h5 && bus_addr[1:0] == 2'b00)
                m_regs[bus_addr[3:2]] = bus_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NL; i++)
                chk({m_tag[i], $sformatf(" led%0d", i)}, {31'd0, led_out[i]}, {31'd0, m_led[i]});
            if (bus_addr[7:4] == 4'h5 && bus_addr[1:0] == 2'b00)
                chk("R10 rdata", bus_rdata, m_regs[bus_addr[3:2]]);
            else
                chk("R10 rdata unmapped", bus_rdata, 32'h0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic count_tr(input int idx, input int ncyc, output int tr);
        logic prev;
        tr = 0;
        @(negedge clk);
        prev = led_out[idx];
        repeat (ncyc) begin
            @(negedge clk);
            if (led_out[idx] !== prev) tr++;
            prev = led_out[idx];
        end
    endtask

    initial begin
        int tr;
        step(3);
        rst_n = 1'b1;
        bus_addr = 8'h50;
        @(negedge clk);
        chk("R1 leds after reset", {17'd0, led_out}, 32'h0);
        chk("R1 word0 after reset", bus_rdata, 32'h0);

        // R2/R4: port0 led0 lit via word0[15:14]
        wr(8'h50, 32'h0000_8000);
        step(2); @(negedge clk);
        chk("R2 R4 port0 led0 lit", {31'd0, led_out[0]}, 32'd1);

        // R4: port2 led1 in word3 bit 16, port4 led2 in word2[31:30]
        wr(8'h5C, 32'h0002_0000);
        wr(8'h58, 32'h8000_0000);
        step(2); @(negedge clk);
        chk("R4 field placement", {17'd0, led_out}, 32'h4081);

        // R3/R11: fixed blink, 4 units period, DIV clocks per unit
        wr(8'h50, 32'h0000_4000);
        step(2);
        count_tr(0, 64, tr);
        chk("R3 R11 blink transitions in 64 cycles", tr, 8);

        // R5/R6: shared lower rule drives port1 led0, port4 led0 sees upper rule
        wr(8'h58, 32'h0);
        wr(8'h5C, 32'h0000_0300);
        wr(8'h50, 32'hC000_2200);
        port_link = 5'h1F; port_speed = 10'b01_01_01_01_01; port_fdx = 5'h1F;
        step(3); @(negedge clk);
        chk("R5 rule word sources", {17'd0, led_out}, 32'h0008);
        port_fdx[1] = 1'b0;
        step(3); @(negedge clk);
        chk("R6 duplex mismatch dark", {31'd0, led_out[3]}, 32'd0);
        port_fdx[1] = 1'b1;
        wr(8'h50, 32'h0000_0800);
        port_link = 5'h0;
        step(3); @(negedge clk);
        chk("R6 power-on light", {31'd0, led_out[3]}, 32'd1);

        // R7: single TX pulse opens a finite blink window
        wr(8'h50, 32'h0000_0012);
        step(1);
        port_tx[1] = 1'b1;
        step(1);
        port_tx[1] = 1'b0;
        count_tr(3, 36, tr);
        chk("R7 window blinks", {31'd0, tr > 0}, 32'd1);
        chk("R7 window expires", {31'd0, led_out[3]}, 32'd0);

        // R8: automatic rate follows speed
        wr(8'h50, 32'h0000_0013);
        port_link[1] = 1'b1; port_speed[3:2] = 2'd2; port_tx[1] = 1'b1;
        step(3);
        count_tr(3, 32, tr);
        chk("R8 auto rate 1000M", tr, 8);
        port_speed[3:2] = 2'd0;
        step(2);
        count_tr(3, 64, tr);
        chk("R8 auto rate 10M", tr, 4);

        // R9: override keeps steady light during activity
        port_speed[3:2] = 2'd2;
        wr(8'h50, 32'h0000_0416);
        step(3);
        count_tr(3, 32, tr);
        chk("R9 override no blink", tr, 0);
        chk("R9 override lit", {31'd0, led_out[3]}, 32'd1);
        wr(8'h50, 32'h0000_0412);
        step(3);
        count_tr(3, 32, tr);
        chk("R7 activity over steady", tr, 8);
        port_tx[1] = 1'b0;

        // R10: unmapped and misaligned writes ignored
        wr(8'h54, 32'h1234_5678);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h56, 32'hFFFF_FFFF);
        bus_addr = 8'h60;
        @(negedge clk);
        chk("R10 unmapped reads zero", bus_rdata, 32'h0);
        step(1); bus_addr = 8'h54;
        @(negedge clk);
        chk("R10 readback word1", bus_rdata, 32'h1234_5678);

        // Randomised traffic, status and register activity
        for (int k = 0; k < 4000; k++) begin
            step(1);
            bus_wr = 1'b0;
            if ($urandom_range(7) == 0) begin
                bus_wr = 1'b1;
                case ($urandom_range(5))
                    0: bus_addr = 8'h50;
                    1: bus_addr = 8'h54;
                    2: bus_addr = 8'h58;
                    3: bus_addr = 8'h5C;
                    4: bus_addr = 8'h60;
                    default: bus_addr = 8'h5A;
                endcase
                bus_wdata = $urandom;
            end else begin
                bus_addr = 8'h50 + 8'($urandom_range(3) * 4);
            end
            if ($urandom_range(15) == 0) begin
                port_link = 5'($urandom); port_speed = 10'($urandom); port_fdx = 5'($urandom);
            end
            for (int p = 0; p < 5; p++) begin
                port_tx[p]  = ($urandom_range(19) == 0);
                port_rx[p]  = ($urandom_range(19) == 0);
                port_col[p] = ($urandom_range(29) == 0);
            end
        end
        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule